// File: doc/BRIEF.md
# Hypervisor Interrupt Queue Status Logic

This block keeps the software-owned head and tail pointer registers of four interrupt queues and turns them into level interrupt requests. The queues are CPU mondo, device mondo, resumable error and nonresumable error. A queue is pending whenever its head pointer differs from its tail pointer. The nonresumable error queue keeps its pointers but never raises a request. Software consumes entries by moving the head pointer, and the producer adds entries by moving the tail pointer. Each write to either pointer re-evaluates that queue's request.

The block also holds a hypervisor state register and a hypervisor trap base register. The state register combines its trap-on-level-zero enable with the current trap level from the core to form a trap-level-zero request. An implementation marker bit in that register always reads as one. The trap base register keeps its 15 low bits at zero.

All requests are registered. A write changes them at the same clock edge that stores the written value. Reads return data combinationally, selected by a read address.

Top module: `hv_irq_status`

## Requirements
- R1: After reset every pointer and the trap base read zero, the state register reads 0x800 (only the marker bit 11 set), and all four interrupt outputs are low.
- R2: `cpu_mondo_irq_o` is high exactly when the CPU mondo head (address 0) differs from its tail (address 1), updated at the edge of the write.
- R3: `dev_mondo_irq_o` is high exactly when the device mondo head (address 2) differs from its tail (address 3), updated at the edge of the write.
- R4: `res_err_irq_o` is high exactly when the resumable error head (address 4) differs from its tail (address 5), updated at the edge of the write.
- R5: The nonresumable error head (address 6) and tail (address 7) are stored and read back, but writing them changes no interrupt output.
- R6: A pointer write keeps the low PTR_W (8) data bits, and a read returns them zero-extended.
- R7: A write to the state register (address 8) stores bits 11:0 with bit 11 forced to one, so a read returns the written bits 11:0 OR 0x800.
- R8: `tlz_irq_o` is high when state bit 0 is set, state bit 2 is clear, and `tl_i` was zero at the previous clock edge. It follows a state write at the same edge and follows `tl_i` one cycle later.
- R9: The trap base register (address 9) always reads bits 14:0 as zero, whatever was written. The upper bits are stored as written.
- R10: Writes to addresses 10 to 15 change no register and no output, and reads of those addresses return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write register select |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | 4 | Read register select |
| rd_data_o | output | DATA_W | Read data, combinational |
| tl_i | input | TL_W | Current trap level |
| cpu_mondo_irq_o | output | 1 | CPU mondo queue pending |
| dev_mondo_irq_o | output | 1 | Device mondo queue pending |
| res_err_irq_o | output | 1 | Resumable error queue pending |
| tlz_irq_o | output | 1 | Trap-level-zero request |

## Verification
For each of the three queues that signal, the bench sweeps every pair of head and tail values from 0 to 15. The upper data bits carry garbage during the sweep. This separates a true inequality test from a comparison of partial bits or of unmasked data. After each write, the bench also checks the other two queues. This exposes crossed address decode between queues.

The bench walks all combinations of the state enable, the hyperprivileged bit and every trap level. This sets the trap-level-zero request apart from conditions that drop a term. The nonresumable pointers, unmapped addresses and trap base values with ones in their low bits are then written. The bench checks that the readback is masked and that the interrupt outputs stay unchanged.

// File: rtl/hv_irq_pkg.sv
package hv_irq_pkg;
  localparam int ADDR_W = 4;
  localparam int NQ     = 4;

  localparam logic [ADDR_W-1:0] RA_STATE = 4'd8;
  localparam logic [ADDR_W-1:0] RA_TBASE = 4'd9;

  // state register fields
  localparam int HS_W     = 12;
  localparam int HS_TLZ   = 0;
  localparam int HS_HPRIV = 2;
  localparam int HS_ID    = 11;
endpackage

// File: rtl/hv_queue_ptrs.sv
module hv_queue_ptrs #(
  parameter int PTR_W   = 8,
  parameter bit HAS_IRQ = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_head_i,
  input  logic             wr_tail_i,
  input  logic [PTR_W-1:0] wr_data_i,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             pend_o
);
  logic [PTR_W-1:0] head_q, tail_q, head_d, tail_d;

  always_comb begin
    head_d = wr_head_i ? wr_data_i : head_q;
    tail_d = wr_tail_i ? wr_data_i : tail_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  generate
    if (HAS_IRQ) begin : g_irq
      logic pend_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= (head_d != tail_d);
      end
      assign pend_o = pend_q;
    end else begin : g_no_irq
      assign pend_o = 1'b0;
    end
  endgenerate

  assign head_o = head_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/hv_state_reg.sv
module hv_state_reg
  import hv_irq_pkg::*;
#(
  parameter int TL_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [HS_W-1:0] wr_data_i,
  input  logic [TL_W-1:0] tl_i,
  output logic [HS_W-1:0] state_o,
  output logic            tlz_o
);
  localparam logic [HS_W-1:0] ID_MASK = HS_W'(1) << HS_ID;

  logic [HS_W-1:0] hs_q, hs_d;
  logic            tlz_q;

  assign hs_d = wr_i ? (wr_data_i | ID_MASK) : hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q  <= ID_MASK;
      tlz_q <= 1'b0;
    end else begin
      hs_q  <= hs_d;
      tlz_q <= hs_d[HS_TLZ] && !hs_d[HS_HPRIV] && (tl_i == '0);
    end
  end

  assign state_o = hs_q;
  assign tlz_o   = tlz_q;
endmodule

// File: rtl/hv_trap_base.sv
module hv_trap_base #(
  parameter int DATA_W = 32,
  parameter int ZERO_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] base_o
);
  logic [DATA_W-ZERO_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   base_q <= '0;
    else if (wr_i) base_q <= wr_data_i[DATA_W-1:ZERO_W];
  end

  assign base_o = {base_q, {ZERO_W{1'b0}}};
endmodule

// File: rtl/hv_irq_status.sv
module hv_irq_status
  import hv_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8,
  parameter int TL_W   = 3,
  parameter int ZERO_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [TL_W-1:0]   tl_i,
  output logic              cpu_mondo_irq_o,
  output logic              dev_mondo_irq_o,
  output logic              res_err_irq_o,
  output logic              tlz_irq_o
);
  localparam logic [DATA_W-1:0] LOW_MASK = (DATA_W'(1) << ZERO_W) - 1;

  logic [PTR_W-1:0]  head_w [NQ];
  logic [PTR_W-1:0]  tail_w [NQ];
  logic [NQ-1:0]     pend_w;
  logic [HS_W-1:0]   hs_w;
  logic [DATA_W-1:0] tba_w;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    hv_queue_ptrs #(
      .PTR_W  (PTR_W),
      .HAS_IRQ(q != NQ - 1)
    ) u_q (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_head_i(wr_en_i && (wr_addr_i == ADDR_W'(2 * q))),
      .wr_tail_i(wr_en_i && (wr_addr_i == ADDR_W'(2 * q + 1))),
      .wr_data_i(wr_data_i[PTR_W-1:0]),
      .head_o   (head_w[q]),
      .tail_o   (tail_w[q]),
      .pend_o   (pend_w[q])
    );
  end

  hv_state_reg #(.TL_W(TL_W)) u_state (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && (wr_addr_i == RA_STATE)),
    .wr_data_i(wr_data_i[HS_W-1:0]),
    .tl_i     (tl_i),
    .state_o  (hs_w),
    .tlz_o    (tlz_irq_o)
  );

  hv_trap_base #(.DATA_W(DATA_W), .ZERO_W(ZERO_W)) u_tba (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && (wr_addr_i == RA_TBASE)),
    .wr_data_i(wr_data_i),
    .base_o   (tba_w)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i < ADDR_W'(2 * NQ)) begin
      if (rd_addr_i[0]) rd_data_o = DATA_W'(tail_w[rd_addr_i[ADDR_W-1:1]]);
      else              rd_data_o = DATA_W'(head_w[rd_addr_i[ADDR_W-1:1]]);
    end else if (rd_addr_i == RA_STATE) begin
      rd_data_o = DATA_W'(hs_w);
    end else if (rd_addr_i == RA_TBASE) begin
      rd_data_o = tba_w & ~LOW_MASK;
    end
  end

  assign cpu_mondo_irq_o = pend_w[0];
  assign dev_mondo_irq_o = pend_w[1];
  assign res_err_irq_o   = pend_w[2];
endmodule

// File: rtl/hv_irq_status_chk.sv
module hv_irq_status_chk
  import hv_irq_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PTR_W  = 8,
  parameter int TL_W   = 3,
  parameter int ZERO_W = 15
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [TL_W-1:0]   tl_i,
  input logic              cpu_mondo_irq_o,
  input logic              dev_mondo_irq_o,
  input logic              res_err_irq_o,
  input logic              tlz_irq_o,
  input logic [PTR_W-1:0]  head_w [NQ],
  input logic [PTR_W-1:0]  tail_w [NQ],
  input logic [HS_W-1:0]   hs_w,
  input logic [DATA_W-1:0] tba_w
);
  p_cpu_pend_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_mondo_irq_o == (head_w[0] != tail_w[0]));
  p_dev_pend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_mondo_irq_o == (head_w[1] != tail_w[1]));
  p_res_pend_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_err_irq_o == (head_w[2] != tail_w[2]));
  p_nres_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (wr_addr_i == 4'd6 || wr_addr_i == 4'd7)) |=>
      ($stable(cpu_mondo_irq_o) && $stable(dev_mondo_irq_o) && $stable(res_err_irq_o)));
  p_id_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_w[HS_ID]);
  p_tlz_level_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlz_irq_o |-> ($past(tl_i) == '0 && hs_w[HS_TLZ] && !hs_w[HS_HPRIV]));
  p_tba_low_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i == RA_TBASE) |-> (rd_data_o[ZERO_W-1:0] == '0));
  p_unmapped_rd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_addr_i > RA_TBASE) |-> (rd_data_o == '0));
endmodule

bind hv_irq_status hv_irq_status_chk #(
  .DATA_W(DATA_W), .PTR_W(PTR_W), .TL_W(TL_W), .ZERO_W(ZERO_W)
) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .wr_addr_i      (wr_addr_i),
  .rd_addr_i      (rd_addr_i),
  .rd_data_o      (rd_data_o),
  .tl_i           (tl_i),
  .cpu_mondo_irq_o(cpu_mondo_irq_o),
  .dev_mondo_irq_o(dev_mondo_irq_o),
  .res_err_irq_o  (res_err_irq_o),
  .tlz_irq_o      (tlz_irq_o),
  .head_w         (head_w),
  .tail_w         (tail_w),
  .hs_w           (hs_w),
  .tba_w          (tba_w)
);

// File: tb/hv_irq_status_test.sv
`timescale 1ns/1ps
module hv_irq_status_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [2:0]  tl = '0;
  logic        cpu_irq, dev_irq, res_irq, tlz_irq;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  logic [7:0] exp_h [4];
  logic [7:0] exp_t [4];

  always #5 clk = ~clk;

  hv_irq_status uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .tl_i(tl),
    .cpu_mondo_irq_o(cpu_irq), .dev_mondo_irq_o(dev_irq),
    .res_err_irq_o(res_irq), .tlz_irq_o(tlz_irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic chk_queue_irqs(input string req);
    chk({req, " cpu"}, {31'd0, cpu_irq}, {31'd0, exp_h[0] != exp_t[0]});
    chk({req, " dev"}, {31'd0, dev_irq}, {31'd0, exp_h[1] != exp_t[1]});
    chk({req, " res"}, {31'd0, res_irq}, {31'd0, exp_h[2] != exp_t[2]});
  endtask

  task automatic chk_all_regs(input string req, input logic [31:0] st, input logic [31:0] tb);
    logic [31:0] d;
    for (int q = 0; q < 4; q++) begin
      rd(4'(2*q), d);   chk(req, d, {24'd0, exp_h[q]});
      rd(4'(2*q+1), d); chk(req, d, {24'd0, exp_t[q]});
    end
    rd(4'd8, d); chk(req, d, st);
    rd(4'd9, d); chk(req, d, tb);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    for (int q = 0; q < 4; q++) begin exp_h[q] = '0; exp_t[q] = '0; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk_queue_irqs("R1");
    chk("R1 tlz", {31'd0, tlz_irq}, 32'd0);
    chk_all_regs("R1 regs", 32'h800, 32'd0);

    // R2 R3 R4 R6: sweep head/tail with garbage upper bits
    for (int q = 0; q < 3; q++) begin
      for (int h = 0; h < 16; h++) begin
        for (int t = 0; t < 16; t++) begin
          wr(4'(2*q), 32'hDEAD_BE00 | 32'(h));
          exp_h[q] = 8'(h);
          chk_queue_irqs(q == 0 ? "R2" : q == 1 ? "R3" : "R4");
          wr(4'(2*q+1), 32'h5A5A_5A00 | 32'(t));
          exp_t[q] = 8'(t);
          chk_queue_irqs(q == 0 ? "R2" : q == 1 ? "R3" : "R4");
        end
      end
      rd(4'(2*q), d);   chk("R6 head", d, {24'd0, exp_h[q]});
      rd(4'(2*q+1), d); chk("R6 tail", d, {24'd0, exp_t[q]});
    end

    // leave one queue pending and one empty
    wr(4'd0, 32'h33); exp_h[0] = 8'h33;
    wr(4'd3, 32'h0F); exp_t[1] = 8'h0F;
    chk_queue_irqs("R2 R3 setup");

    // R5 nonresumable pointers
    for (int v = 0; v < 8; v++) begin
      wr(4'd6, 32'hFFFF_FF00 | 32'(v * 37)); exp_h[3] = 8'(v * 37);
      chk_queue_irqs("R5");
      wr(4'd7, 32'(v * 91 + 1)); exp_t[3] = 8'(v * 91 + 1);
      chk_queue_irqs("R5");
      rd(4'd6, d); chk("R5 head", d, {24'd0, exp_h[3]});
      rd(4'd7, d); chk("R5 tail", d, {24'd0, exp_t[3]});
    end

    // R7 R8 state register and trap-level-zero
    for (int s = 0; s < 4; s++) begin
      for (int lv = 0; lv < 8; lv++) begin
        logic [31:0] wv;
        wv = 32'hFFFF_F000 | 32'((s & 1) ? 1 : 0) | 32'((s & 2) ? 4 : 0) | 32'h0A0;
        @(negedge clk); tl = 3'(lv);
        wr(4'd8, wv);
        chk("R8 tlz at write edge", {31'd0, tlz_irq},
            {31'd0, (s == 1) && (lv == 0)});
        rd(4'd8, d);
        chk("R7 state readback", d, (wv & 32'hFFF) | 32'h800);
      end
    end
    // R8 tl_i follow with tlz enabled
    wr(4'd8, 32'h1);
    for (int lv = 7; lv >= 0; lv--) begin
      @(negedge clk); tl = 3'(lv);
      @(posedge clk); #1;
      chk("R8 tl follow", {31'd0, tlz_irq}, {31'd0, lv == 0});
    end
    @(negedge clk); tl = 3'd2;
    @(posedge clk); #1;
    chk("R8 tl rise", {31'd0, tlz_irq}, 32'd0);
    @(negedge clk); tl = 3'd0;
    wr(4'd8, 32'h0);
    chk("R8 disable", {31'd0, tlz_irq}, 32'd0);

    // R9 trap base
    for (int i = 0; i < 8; i++) begin
      logic [31:0] tv;
      tv = 32'h1234_5678 * 32'(i + 1) ^ 32'h0000_7FFF;
      wr(4'd9, tv);
      rd(4'd9, d);
      chk("R9 trap base", d, tv & 32'hFFFF_8000);
    end

    // R10 unmapped addresses
    for (int a = 10; a < 16; a++) begin
      wr(4'(a), 32'hFFFF_FFFF);
      chk_queue_irqs("R10 irq");
      chk("R10 tlz", {31'd0, tlz_irq}, 32'd0);
      rd(4'(a), d); chk("R10 read", d, 32'd0);
      chk_all_regs("R10 regs", 32'h800, (32'h1234_5678 * 32'd8 ^ 32'h7FFF) & 32'hFFFF_8000);
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule